// File: doc/BRIEF.md
# Multichannel Delta-Sigma Result Reader (Shared Serial Line)

This block sits on the host side of a simultaneous-sampling delta-sigma converter that runs its SPI-style protocol with every channel multiplexed onto one data line. It watches the converter's active-low data-ready line. When that line falls, the block waits a short lead-in and then drives a burst of serial clocks. It shifts in one 24-bit result per channel, most significant bit first. The first channel comes first and the rest follow in ascending order. Each finished result is presented on a parallel bus with a one-cycle strobe, its channel index and a marker on the last channel of the frame.

The block runs on `clk`, which must be twice the converter's master clock. One serial-clock half period is 2^`div_sel` cycles of `clk`. Settings 0 to 3 therefore give a serial clock of the master clock divided by 1, 2, 4 or 8. A full read lasts max(2^div_sel, 2) + 48·NUM_CH·2^div_sel cycles of `clk`. The integrator must pick `div_sel` so that this fits inside one conversion period, which is 512 to 5120 `clk` cycles depending on the converter mode. If a new data-ready edge arrives while a read is still running, the block flags an overrun and starts reading the new frame.

Top module: `adc_tdm_reader`

## Requirements
- R1: While reset is active, `sclk`, `word_valid`, `frame_last` and `overrun` are all low.
- R2: A high-to-low change of `drdy_n`, first seen at a `clk` edge E, starts a frame. `sclk` stays low after E, and its first rise comes at the edge max(H,2) cycles after E, where H = 2^div_sel. This is at least one master-clock period.
- R3: Within a frame, every `sclk` high phase and low phase lasts H `clk` cycles. The frame has exactly 24·NUM_CH rising edges, after which `sclk` rests low.
- R4: `sdo` is sampled at the `clk` edge that drives `sclk` high. The 24 samples of a word assemble MSB first into `word_data`.
- R5: `word_valid` is high for exactly one cycle, starting at the edge that takes the 24th sample of a word. `word_chan` reads 0 for the first word and counts up to NUM_CH-1.
- R6: `frame_last` is high only together with `word_valid`, and only for channel NUM_CH-1.
- R7: `div_sel` is captured at the frame start. A change to it during a frame has no effect on that frame's `sclk` timing.
- R8: A `drdy_n` falling edge seen while a frame is in progress raises `overrun` for one cycle and forces `sclk` low. This applies from the frame's start edge up to and including the edge that ends its last high phase. The new frame then proceeds exactly as in R2 and R3, and the old frame's unread words are never delivered.
- R9: A `drdy_n` falling edge that arrives after a frame has finished does not raise `overrun`.
- R10: If the restarting edge of R8 is the same edge that samples the last bit of the final word, that word is still delivered with `frame_last`, in the same cycle as `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the converter master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_sel | input | DIV_W | Serial-clock half period select, H = 2^div_sel clk cycles |
| drdy_n | input | 1 | Converter data-ready, falling edge marks new results |
| sdo | input | 1 | Shared serial data line from the converter |
| sclk | output | 1 | Serial clock to the converter |
| word_valid | output | 1 | One-cycle strobe for a completed result |
| word_data | output | WORD_W | Completed result, held until the next strobe |
| word_chan | output | CH_W | Channel index of the result, 0 = first channel |
| frame_last | output | 1 | High with the strobe of the final channel |
| overrun | output | 1 | One-cycle pulse when a frame is cut short by a new edge |

## Verification
Two events can land on the same cycle: delivery of the final word of a frame, and an overrun restart. The bench provokes this by timing a new data-ready fall so that it is sampled on exactly the edge that takes the last bit. That edge is max(H,2) + 2H·(24·NUM_CH − 1) cycles after the start. The bench expects the strobe, `frame_last`, the correct data and `overrun` all in the following cycle, and a clean full read of the new frame after it. The behavioural model checks `sclk`, the strobe, the overrun pulse and the word contents on every clock against the timing formulas. It checks these across all four divider settings, a mid-frame divider change and a mid-frame restart.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  // Serial clock sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } phase_e;
endpackage

// File: rtl/adcrd_edge_det.sv
module adcrd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic start
);
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_n;
  end

  // previous sample high, current sample low
  assign start = line_q & ~line_n;
endmodule

// File: rtl/adcrd_sclk_seq.sv
module adcrd_sclk_seq
  import adcrd_pkg::*;
#(
  parameter int DIV_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             frame_done,
  output logic             sclk,
  output logic             sample_en,
  output logic             overrun
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic             sclk_q, sclk_d;
  logic             over_q, over_d;
  logic [CNT_W-1:0] lead_len, end_val;
  logic             phase_end, busy;

  always_comb begin
    lead_len  = (half_q < CNT_W'(2)) ? CNT_W'(2) : half_q;
    end_val   = (phase_q == PH_LEAD) ? lead_len : half_q;
    busy      = (phase_q != PH_IDLE);
    phase_end = busy && (cnt_q == end_val - CNT_W'(1));
    sample_en = phase_end && ((phase_q == PH_LEAD) || (phase_q == PH_LOW));
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    sclk_d  = sclk_q;
    over_d  = start && busy;
    if (start) begin
      phase_d = PH_LEAD;
      cnt_d   = '0;
      half_d  = CNT_W'(1) << div_sel;
      sclk_d  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: ;
        PH_LEAD, PH_LOW: begin
          if (phase_end) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
            sclk_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (phase_end) begin
            phase_d = frame_done ? PH_IDLE : PH_LOW;
            cnt_d   = '0;
            sclk_d  = 1'b0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      half_q  <= CNT_W'(1);
      sclk_q  <= 1'b0;
      over_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      sclk_q  <= sclk_d;
      over_q  <= over_d;
    end
  end

  assign sclk    = sclk_q;
  assign overrun = over_q;
endmodule

// File: rtl/adcrd_deser.sv
module adcrd_deser #(
  parameter int NUM_CH = 4,
  parameter int WORD_W = 24,
  parameter int CH_W   = 2,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample_en,
  input  logic              sdo,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [CH_W-1:0]   word_chan,
  output logic              frame_last,
  output logic              frame_done
);
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              done_q, done_d;
  logic              valid_q, valid_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              last_q, last_d;
  logic              word_end, last_ch;

  always_comb begin
    word_end = sample_en && (bit_q == BIT_W'(WORD_W-1));
    last_ch  = (ch_q == CH_W'(NUM_CH-1));
    shreg_d  = sample_en ? {shreg_q[WORD_W-2:0], sdo} : shreg_q;
    bit_d    = bit_q;
    ch_d     = ch_q;
    done_d   = done_q;
    if (start) begin
      bit_d  = '0;
      ch_d   = '0;
      done_d = 1'b0;
    end else if (sample_en) begin
      if (word_end) begin
        bit_d  = '0;
        ch_d   = last_ch ? '0 : ch_q + CH_W'(1);
        done_d = done_q | last_ch;
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
    // word delivery is independent of a restart on the same edge
    valid_d = word_end;
    data_d  = word_end ? shreg_d : data_q;
    chan_d  = word_end ? ch_q : chan_q;
    last_d  = word_end && last_ch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bit_q   <= '0;
      ch_q    <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      chan_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      ch_q    <= ch_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      chan_q  <= chan_d;
      last_q  <= last_d;
    end
  end

  assign word_valid = valid_q;
  assign word_data  = data_q;
  assign word_chan  = chan_q;
  assign frame_last = last_q;
  assign frame_done = done_q;
endmodule

// File: rtl/adc_tdm_reader.sv
module adc_tdm_reader #(
  parameter int NUM_CH = 4,
  parameter int WORD_W = 24,
  parameter int DIV_W  = 2,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int MAX_HALF = 1 << ((1 << DIV_W) - 1),
  localparam int CNT_W    = $clog2(MAX_HALF) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              drdy_n,
  input  logic              sdo,
  output logic              sclk,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [CH_W-1:0]   word_chan,
  output logic              frame_last,
  output logic              overrun
);
  logic [1:0] rs_q;
  logic       rst_sync_n;
  logic       start, sample_en, frame_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  adcrd_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .line_n (drdy_n),
    .start  (start)
  );

  adcrd_sclk_seq #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .div_sel    (div_sel),
    .frame_done (frame_done),
    .sclk       (sclk),
    .sample_en  (sample_en),
    .overrun    (overrun)
  );

  adcrd_deser #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .CH_W(CH_W), .BIT_W(BIT_W)) u_deser (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .sample_en  (sample_en),
    .sdo        (sdo),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_chan  (word_chan),
    .frame_last (frame_last),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/adcrd_chk.sv
module adcrd_chk (
  input logic clk,
  input logic rst_n,
  input logic drdy_n,
  input logic sclk,
  input logic word_valid,
  input logic frame_last,
  input logic overrun
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!sclk && !word_valid && !frame_last && !overrun)
        else $error("outputs active during reset");
    end
  end

  assert_start_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drdy_n) && !drdy_n) |=> (!sclk ##1 !sclk))
    else $error("serial clock rose too early after data-ready fall");

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid)
    else $error("word strobe longer than one cycle");

  assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |-> word_valid)
    else $error("frame end marker without word strobe");

  assert_overrun_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun)
    else $error("overrun longer than one cycle");

  assert_overrun_sclk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !sclk)
    else $error("serial clock high on restart");
endmodule

bind adc_tdm_reader adcrd_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .drdy_n     (drdy_n),
  .sclk       (sclk),
  .word_valid (word_valid),
  .frame_last (frame_last),
  .overrun    (overrun)
);

// File: tb/adc_tdm_reader_tb_top.sv
module adc_tdm_reader_tb_top;
  localparam int NCH = 4;
  localparam int WW  = 24;
  localparam int NB  = NCH * WW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  div_sel = 2'd0;
  logic        drdy_n = 1'b1;
  logic        sdo = 1'b0;
  logic        sclk, word_valid, frame_last, overrun;
  logic [23:0] word_data;
  logic [1:0]  word_chan;

  adc_tdm_reader #(.NUM_CH(NCH), .WORD_W(WW), .DIV_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .drdy_n(drdy_n), .sdo(sdo),
    .sclk(sclk), .word_valid(word_valid), .word_data(word_data),
    .word_chan(word_chan), .frame_last(frame_last), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int    total = 0, bad = 0, cyc = 0;
  bit    model_on = 1'b0, active = 1'b0, prev_drdy = 1'b1;
  int    t0 = 0, hh = 1, ll = 2, fidx = 0;
  bit    exp_sclk = 1'b0, exp_valid = 1'b0, exp_over = 1'b0, exp_last = 1'b0;
  int    exp_chan = 0;
  logic [23:0] exp_data = '0;
  string sclk_tag = "R3";
  string scen = "R3";
  int    ptr = NB;
  bit    adc_restart = 1'b0, prev_sclk = 1'b0;

  function automatic logic [23:0] pat(input int f, input int c);
    logic [31:0] v;
    v = 32'(f) * 32'h9E3779B1 + 32'(c) * 32'h7F4A7C15 + 32'h01234567;
    return v[27:4];
  endfunction

  function automatic int frame_len(input int d);
    int h, l;
    h = 1 << d;
    l = (h < 2) ? 2 : h;
    return l + 2 * h * NB;
  endfunction

  task automatic note(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // behavioural reference: timing derived from the frame start edge
  always @(posedge clk) begin
    int e, k;
    bit st;
    cyc++;
    if (model_on) begin
      st = prev_drdy && !drdy_n;
      prev_drdy = drdy_n;
      exp_valid = 1'b0;
      exp_last  = 1'b0;
      exp_over  = 1'b0;
      if (active) begin
        e = cyc - t0;
        if (e >= ll && (e - ll) % (2 * hh) == 0) begin
          k = (e - ll) / (2 * hh);
          if (k < NB && k % WW == WW - 1) begin
            exp_valid = 1'b1;
            exp_chan  = k / WW;
            exp_last  = (exp_chan == NCH - 1);
            exp_data  = pat(fidx, exp_chan);
          end
        end
        exp_over = st && (e <= ll + 2 * hh * (NB - 1) + hh);
      end
      if (st) begin
        active = 1'b1;
        t0 = cyc;
        hh = 1 << div_sel;
        ll = (hh < 2) ? 2 : hh;
        fidx++;
        adc_restart = 1'b1;
      end
      exp_sclk = 1'b0;
      if (active) begin
        e = cyc - t0;
        sclk_tag = (e <= ll) ? "R2" : "R3";
        if (e >= ll && (e - ll) % (2 * hh) < hh && (e - ll) / (2 * hh) < NB) exp_sclk = 1'b1;
        if (e > ll + 2 * hh * (NB - 1) + hh) active = 1'b0;
      end
    end
  end

  // per-cycle comparison, then converter model driving sdo
  always @(negedge clk) begin
    logic [23:0] w;
    if (model_on) begin
      note(sclk == exp_sclk, $sformatf("%s (%s) sclk cyc=%0d act=%0b exp=%0b", sclk_tag, scen, cyc, sclk, exp_sclk));
      note(word_valid == exp_valid, $sformatf("R5 (%s) word_valid cyc=%0d act=%0b exp=%0b", scen, cyc, word_valid, exp_valid));
      note(overrun == exp_over, $sformatf("R8 (%s) overrun cyc=%0d act=%0b exp=%0b", scen, cyc, overrun, exp_over));
      note(frame_last == exp_last, $sformatf("R6 (%s) frame_last cyc=%0d act=%0b exp=%0b", scen, cyc, frame_last, exp_last));
      if (exp_valid) begin
        note(word_data == exp_data, $sformatf("R4 (%s) word_data act=%h exp=%h", scen, word_data, exp_data));
        note(int'(word_chan) == exp_chan, $sformatf("R5 (%s) word_chan act=%0d exp=%0d", scen, word_chan, exp_chan));
      end
    end
    if (adc_restart) begin
      ptr = 0;
      adc_restart = 1'b0;
    end else if (prev_sclk && !sclk) begin
      ptr++;
      if (ptr == 1) drdy_n = 1'b1;
    end
    prev_sclk = sclk;
    w = pat(fidx, ptr / WW);
    sdo = (ptr < NB) ? w[WW - 1 - (ptr % WW)] : 1'b0;
  end

  task automatic run_frame(input int d);
    @(negedge clk);
    div_sel = 2'(d);
    drdy_n = 1'b0;
    repeat (frame_len(d) + 6) @(negedge clk);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      note(!sclk && !word_valid && !overrun && !frame_last,
           $sformatf("R1 reset outputs act=%b%b%b%b exp=0000", sclk, word_valid, overrun, frame_last));
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    // all divider settings
    for (int d = 0; d < 4; d++) begin
      scen = "R3";
      run_frame(d);
    end

    // R9: start right after a completed frame
    scen = "R9";
    @(negedge clk);
    div_sel = 2'd0;
    drdy_n = 1'b0;
    @(negedge clk);
    note(!overrun, $sformatf("R9 overrun after completed frame act=%0b exp=0", overrun));
    repeat (frame_len(0) + 6) @(negedge clk);

    // R7: divider change mid-frame is ignored
    scen = "R7";
    @(negedge clk);
    div_sel = 2'd1;
    drdy_n = 1'b0;
    repeat (40) @(negedge clk);
    div_sel = 2'd3;
    repeat (frame_len(1)) @(negedge clk);
    div_sel = 2'd0;
    repeat (8) @(negedge clk);

    // R8: restart mid-frame
    scen = "R8";
    @(negedge clk);
    div_sel = 2'd0;
    drdy_n = 1'b0;
    repeat (100) @(negedge clk);
    drdy_n = 1'b0;
    @(negedge clk);
    note(overrun && !sclk, $sformatf("R8 restart overrun/sclk act=%0b/%0b exp=1/0", overrun, sclk));
    repeat (frame_len(0) + 6) @(negedge clk);

    // R10: restart on the edge sampling the final bit
    scen = "R10";
    @(negedge clk);
    div_sel = 2'd1;
    drdy_n = 1'b0;
    repeat (2 + 4 * (NB - 1)) @(negedge clk);
    drdy_n = 1'b0;
    @(negedge clk);
    note(word_valid && frame_last && overrun,
         $sformatf("R10 collision valid/last/overrun act=%0b%0b%0b exp=111", word_valid, frame_last, overrun));
    note(word_data == pat(fidx - 1, NCH - 1),
         $sformatf("R10 collision word act=%h exp=%h", word_data, pat(fidx - 1, NCH - 1)));
    repeat (frame_len(1) + 6) @(negedge clk);

    repeat (10) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule